// File: doc/BRIEF.md
# Serial ADC configure-and-read controller

This block sequences one complete software-configured access to a three-channel-pair successive-approximation ADC over its serial port. After a start request it gives the converter a hardware reset pulse. It then sends the caller's 32-bit control word in a frame-synchronised serial frame and fires the shared conversion-start line. It waits for the converter's busy line to go high and then low again. Finally it opens a second frame that sends the same control word once more while it collects three serial data lanes in parallel.

The caller supplies the control word unchanged. The controller does not interpret the word. The channel-pair enables in bits 31..29, busy-pin mode in bit 21, register-update enable in bit 16, register readback in bit 17 and internal reference in bit 25 all reach the converter exactly as given. Because the converter must see a control word on every access, the readback frame carries the word too. When the converter does not answer on its busy line within bounded windows, the controller raises an error flag and returns to idle without reading.

Top module: `adc_cfg_reader`

## Requirements
- R1: Each accepted start produces one pulse on `adc_rst_o` that lasts exactly RST_CYC = ceil(RST_MIN_NS / CLK_PERIOD_NS) system cycles. With the defaults this is 13 cycles, which is at least 50 ns. The pulse ends before the first frame begins.
- R2: Outside a frame, `adc_fs_n_o` and `adc_sclk_o` are high. A frame holds `adc_fs_n_o` low for exactly 32 SCLK periods (64·SCLK_HALF system cycles) with 32 falling SCLK edges. `adc_sclk_o` is high when the frame sync returns high.
- R3: The configuration frame sends `ctrl_word_i` as captured at the accepted start, MSB (bit 31) first and unmodified. SDI changes only on rising SCLK and is stable across every falling SCLK edge.
- R4: After the configuration frame ends, `adc_convst_o` pulses high for exactly CONV_CYC cycles, once per access, and never while frame sync is low.
- R5: The read frame starts only after busy has been seen high and then low again.
- R6: The read frame resends the same control word. It samples `adc_sdo_i[k]` on each falling SCLK, MSB first, into `res<k>_o` for k = 0, 1, 2.
- R7: `done_o` is high for exactly one cycle per successful access. The three results are valid then and hold until the next successful access.
- R8: If busy is not seen high within BUSY_RISE_MAX cycles after the start pulse, `err_o` goes high. The controller returns to idle with no read frame, no done pulse and unchanged results.
- R9: If busy is not seen low within BUSY_FALL_MAX cycles after it rose, the same error handling as R8 applies.
- R10: `err_o` stays high until the next accepted start and clears in the cycle after it.
- R11: A start request while an access is in progress is ignored: no extra frames, and the word in use does not change.
- R12: After reset, frame sync, SCLK and SDI idle high/high/any, the reset and conversion-start outputs are low, `done_o` and `err_o` are low and the results are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one access sequence (taken in idle only) |
| ctrl_word_i | input | 32 | Control word sent in both frames |
| adc_rst_o | output | 1 | Converter hardware reset, active high |
| adc_convst_o | output | 1 | Shared conversion start for all channel pairs |
| adc_busy_i | input | 1 | Converter busy indication (asynchronous) |
| adc_fs_n_o | output | 1 | Frame sync, active low |
| adc_sclk_o | output | 1 | Serial clock, idles high |
| adc_sdi_o | output | 1 | Serial data to the converter |
| adc_sdo_i | input | 3 | Serial data lanes from the converter, bit k is lane k |
| res0_o | output | 32 | Word captured from lane 0 |
| res1_o | output | 32 | Word captured from lane 1 |
| res2_o | output | 32 | Word captured from lane 2 |
| done_o | output | 1 | One-cycle strobe, results valid |
| err_o | output | 1 | Busy handshake timed out |

## Verification
A behavioural converter model answers the frames and runs the busy handshake. A table of control words and lane data walks the main path. The words mix set and clear readback bits, all-zero and all-one lanes, and isolated MSB and LSB ones. These patterns separate bit-order faults, lane swaps and a missing second frame, and show whether a readback truly echoes the sent word. Directed runs cover a busy line that never rises and one that never falls, the clearing of the error at the next start, and a start pulse injected during the busy wait.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
  localparam int unsigned FRAME_BITS = 32;
  localparam int unsigned N_LANES    = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST,
    ST_CFG_LOAD,
    ST_CFG_SHIFT,
    ST_CONV,
    ST_WAIT_HI,
    ST_WAIT_LO,
    ST_RD_LOAD,
    ST_RD_SHIFT,
    ST_FINISH,
    ST_FAIL
  } seq_state_e;
endpackage

// File: rtl/adc_sclk_div.sv
// Half-period tick generator for the serial clock; counts only while a frame runs.
module adc_sclk_div #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == CNT_TOP);

  always_comb begin
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_busy_sync.sv
// Synchroniser for the converter busy line; depth picked by parameter.
module adc_busy_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  output logic busy_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= busy_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= {ff_q[STAGES-2:0], busy_i};
      end
    end
  endgenerate

  assign busy_o = ff_q[STAGES-1];
endmodule

// File: rtl/adc_frame_shift.sv
// One serial frame: word out MSB first, optional parallel capture of all lanes.
module adc_frame_shift #(
  parameter int unsigned BITS  = 32,
  parameter int unsigned LANES = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  load_i,
  input  logic                  capture_i,
  input  logic [BITS-1:0]       word_i,
  input  logic [LANES-1:0]      sdo_i,
  output logic                  active_o,
  output logic                  fin_o,
  output logic                  sclk_o,
  output logic                  sdi_o,
  output logic [LANES*BITS-1:0] cap_o
);
  localparam int unsigned BW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(BITS - 1);

  logic            active_q, active_d;
  logic            sclk_q, sclk_d;
  logic            capen_q, capen_d;
  logic [BW-1:0]   bit_q, bit_d;
  logic [BITS-1:0] sr_q, sr_d;
  logic            fall_tick, rise_tick;

  // Falling SCLK is the sample point, rising SCLK advances the output bit.
  assign fall_tick = active_q & tick_i & sclk_q;
  assign rise_tick = active_q & tick_i & ~sclk_q;
  assign fin_o     = rise_tick & (bit_q == LAST_BIT);

  always_comb begin
    active_d = active_q;
    sclk_d   = sclk_q;
    capen_d  = capen_q;
    bit_d    = bit_q;
    sr_d     = sr_q;
    if (load_i && !active_q) begin
      active_d = 1'b1;
      sclk_d   = 1'b1;
      capen_d  = capture_i;
      bit_d    = '0;
      sr_d     = word_i;
    end
    if (fall_tick) sclk_d = 1'b0;
    if (rise_tick) begin
      sclk_d = 1'b1;
      if (bit_q == LAST_BIT) begin
        active_d = 1'b0;
      end else begin
        bit_d = bit_q + BW'(1);
        sr_d  = {sr_q[BITS-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b1;
      capen_q  <= 1'b0;
      bit_q    <= '0;
      sr_q     <= '0;
    end else begin
      active_q <= active_d;
      sclk_q   <= sclk_d;
      capen_q  <= capen_d;
      bit_q    <= bit_d;
      sr_q     <= sr_d;
    end
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [BITS-1:0] lane_q, lane_d;
      always_comb begin
        if (fall_tick && capen_q) lane_d = {lane_q[BITS-2:0], sdo_i[g]};
        else                      lane_d = lane_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
      end
      assign cap_o[g*BITS +: BITS] = lane_q;
    end
  endgenerate

  assign active_o = active_q;
  assign sclk_o   = sclk_q;
  assign sdi_o    = sr_q[BITS-1];
endmodule

// File: rtl/adc_cfg_reader.sv
// Reset, configure, convert, wait on busy, read back three lanes.
module adc_cfg_reader
  import adc_ctl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned RST_MIN_NS    = 50,
  parameter int unsigned SCLK_HALF     = 2,
  parameter int unsigned CONV_CYC      = 4,
  parameter int unsigned BUSY_RISE_MAX = 64,
  parameter int unsigned BUSY_FALL_MAX = 4096,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [31:0] ctrl_word_i,
  output logic        adc_rst_o,
  output logic        adc_convst_o,
  input  logic        adc_busy_i,
  output logic        adc_fs_n_o,
  output logic        adc_sclk_o,
  output logic        adc_sdi_o,
  input  logic [2:0]  adc_sdo_i,
  output logic [31:0] res0_o,
  output logic [31:0] res1_o,
  output logic [31:0] res2_o,
  output logic        done_o,
  output logic        err_o
);
  localparam int unsigned RST_CYC  = (RST_MIN_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int unsigned MAX_A    = (RST_CYC > CONV_CYC) ? RST_CYC : CONV_CYC;
  localparam int unsigned MAX_B    = (BUSY_RISE_MAX > BUSY_FALL_MAX) ? BUSY_RISE_MAX : BUSY_FALL_MAX;
  localparam int unsigned TMR_MAX  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned TW       = $clog2(TMR_MAX + 1);
  localparam logic [TW-1:0] T_RST  = TW'(RST_CYC - 1);
  localparam logic [TW-1:0] T_CONV = TW'(CONV_CYC - 1);
  localparam logic [TW-1:0] T_RISE = TW'(BUSY_RISE_MAX - 1);
  localparam logic [TW-1:0] T_FALL = TW'(BUSY_FALL_MAX - 1);

  seq_state_e state_q, state_d;
  logic [TW-1:0]          tmr_q;
  logic [FRAME_BITS-1:0]  word_q;
  logic [FRAME_BITS-1:0]  res_q [N_LANES];
  logic                   err_q, rst_pulse_q, convst_q;
  logic                   accept;
  logic                   busy_s;
  logic                   tick, fr_active, fr_fin, fr_load, fr_cap;
  logic [N_LANES*FRAME_BITS-1:0] cap_bus;

  adc_busy_sync #(.STAGES(SYNC_STAGES)) i_busy_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy_i (adc_busy_i),
    .busy_o (busy_s)
  );

  adc_sclk_div #(.HALF_DIV(SCLK_HALF)) i_sclk_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (fr_active),
    .tick_o (tick)
  );

  adc_frame_shift #(.BITS(FRAME_BITS), .LANES(N_LANES)) i_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .load_i    (fr_load),
    .capture_i (fr_cap),
    .word_i    (word_q),
    .sdo_i     (adc_sdo_i),
    .active_o  (fr_active),
    .fin_o     (fr_fin),
    .sclk_o    (adc_sclk_o),
    .sdi_o     (adc_sdi_o),
    .cap_o     (cap_bus)
  );

  assign accept = (state_q == ST_IDLE) && start_i;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    fr_load = 1'b0;
    fr_cap  = 1'b0;
    unique case (state_q)
      ST_IDLE:      if (start_i) state_d = ST_RST;
      ST_RST:       if (tmr_q == T_RST) state_d = ST_CFG_LOAD;
      ST_CFG_LOAD:  begin fr_load = 1'b1; state_d = ST_CFG_SHIFT; end
      ST_CFG_SHIFT: if (fr_fin) state_d = ST_CONV;
      ST_CONV:      if (tmr_q == T_CONV) state_d = ST_WAIT_HI;
      ST_WAIT_HI: begin
        if (busy_s)               state_d = ST_WAIT_LO;
        else if (tmr_q == T_RISE) state_d = ST_FAIL;
      end
      ST_WAIT_LO: begin
        if (!busy_s)              state_d = ST_RD_LOAD;
        else if (tmr_q == T_FALL) state_d = ST_FAIL;
      end
      ST_RD_LOAD:   begin fr_load = 1'b1; fr_cap = 1'b1; state_d = ST_RD_SHIFT; end
      ST_RD_SHIFT:  if (fr_fin) state_d = ST_FINISH;
      ST_FINISH:    state_d = ST_IDLE;
      ST_FAIL:      state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  // Sequencer registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      tmr_q       <= '0;
      rst_pulse_q <= 1'b0;
      convst_q    <= 1'b0;
      err_q       <= 1'b0;
      word_q      <= '0;
    end else begin
      state_q     <= state_d;
      tmr_q       <= (state_d != state_q) ? '0 : tmr_q + TW'(1);
      rst_pulse_q <= (state_d == ST_RST);
      convst_q    <= (state_d == ST_CONV);
      if (accept)                    word_q <= ctrl_word_i;
      if (accept)                    err_q  <= 1'b0;
      else if (state_q == ST_FAIL)   err_q  <= 1'b1;
    end
  end

  // Result registers, one per lane
  generate
    for (genvar k = 0; k < N_LANES; k++) begin : g_res
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res_q[k] <= '0;
        end else if (state_q == ST_RD_SHIFT && fr_fin) begin
          res_q[k] <= cap_bus[k*FRAME_BITS +: FRAME_BITS];
        end
      end
    end
  endgenerate

  assign adc_rst_o    = rst_pulse_q;
  assign adc_convst_o = convst_q;
  assign adc_fs_n_o   = ~fr_active;
  assign res0_o       = res_q[0];
  assign res1_o       = res_q[1];
  assign res2_o       = res_q[2];
  assign done_o       = (state_q == ST_FINISH);
  assign err_o        = err_q;
endmodule

// File: rtl/adc_cfg_reader_chk.sv
module adc_cfg_reader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        adc_rst_o,
  input logic        adc_convst_o,
  input logic        adc_fs_n_o,
  input logic        adc_sclk_o,
  input logic        adc_sdi_o,
  input logic        done_o,
  input logic        err_o
);
  // R2: serial clock idles high whenever no frame is open
  a_r2_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    adc_fs_n_o |-> adc_sclk_o);

  // R2: frame sync returns high only with SCLK high
  a_r2_frame_end_sclk_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_fs_n_o) |-> adc_sclk_o);

  // R3: SDI stable across every falling SCLK inside a frame
  a_r3_sdi_stable_at_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_fs_n_o && $fell(adc_sclk_o)) |-> $stable(adc_sdi_o));

  // R4: conversion start never inside a frame
  a_r4_convst_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    adc_convst_o |-> adc_fs_n_o);

  // R1: converter reset never overlaps a frame or a conversion start
  a_r1_reset_alone: assert property (@(posedge clk) disable iff (!rst_n)
    adc_rst_o |-> (adc_fs_n_o && !adc_convst_o));

  // R7: done is a single-cycle strobe
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: an error is never reported together with done
  a_r8_err_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !done_o);

  // R10: error clears only after a start request
  a_r10_err_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_o) |-> $past(start_i));
endmodule

bind adc_cfg_reader adc_cfg_reader_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .adc_rst_o    (adc_rst_o),
  .adc_convst_o (adc_convst_o),
  .adc_fs_n_o   (adc_fs_n_o),
  .adc_sclk_o   (adc_sclk_o),
  .adc_sdi_o    (adc_sdi_o),
  .done_o       (done_o),
  .err_o        (err_o)
);

// File: tb/test_adc_cfg_reader.sv
`timescale 1ns/1ps
module test_adc_cfg_reader;
  localparam int RST_CYC   = 13;   // ceil(50 / 4)
  localparam int FRAME_CYC = 128;  // 32 periods * 2 * SCLK_HALF(2)
  localparam int CONV_CYC  = 4;

  // {ctrl, lane0, lane1, lane2}
  localparam logic [127:0] VEC [4] = '{
    {32'hE001_0000, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_F0F0},
    {32'hE203_03FF, 32'hDEAD_BEEF, 32'h0000_0000, 32'hFFFF_FFFF},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h8000_0000},
    {32'hE001_5555, 32'hAAAA_5555, 32'h5555_AAAA, 32'hC3C3_3C3C}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] ctrl_word_i = '0;
  logic        adc_rst_o, adc_convst_o, adc_fs_n_o, adc_sclk_o, adc_sdi_o;
  logic        adc_busy_i;
  logic [2:0]  adc_sdo_i;
  logic [31:0] res0_o, res1_o, res2_o;
  logic        done_o, err_o;

  always #2 clk = ~clk;

  adc_cfg_reader i_adc_cfg_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctrl_word_i(ctrl_word_i),
    .adc_rst_o(adc_rst_o), .adc_convst_o(adc_convst_o), .adc_busy_i(adc_busy_i),
    .adc_fs_n_o(adc_fs_n_o), .adc_sclk_o(adc_sclk_o), .adc_sdi_o(adc_sdi_o),
    .adc_sdo_i(adc_sdo_i), .res0_o(res0_o), .res1_o(res1_o), .res2_o(res2_o),
    .done_o(done_o), .err_o(err_o)
  );

  // ---------------- converter model (negedge only) ----------------
  logic        mdl_clr = 1'b0;
  int          busy_mode = 1;       // 0: never rises, 1: normal, 2: stuck high
  logic [31:0] lane_d [3];
  logic [31:0] out_sr [3];
  logic [31:0] in_sr, cfg_word;
  logic [31:0] frm_word [4];
  int          frm_bits [4], frm_len [4], conv_at_fs [4];
  logic        busy_at_fs [4];
  int          frm_cnt, nfall, flen, rst_cnt, conv_cnt, done_cnt, bz_tmr;
  logic        busy_r, prev_fs, prev_sclk, prev_conv;

  assign adc_busy_i = busy_r;
  assign adc_sdo_i  = {out_sr[2][31], out_sr[1][31], out_sr[0][31]};

  always @(negedge clk) begin
    if (!rst_n || mdl_clr) begin
      frm_cnt = 0; rst_cnt = 0; conv_cnt = 0; done_cnt = 0; bz_tmr = 0;
      busy_r = 1'b0; nfall = 0; flen = 0; in_sr = '0;
      for (int k = 0; k < 3; k++) out_sr[k] = '0;
      for (int f = 0; f < 4; f++) begin
        frm_word[f] = '0; frm_bits[f] = 0; frm_len[f] = 0;
        conv_at_fs[f] = -1; busy_at_fs[f] = 1'b1;
      end
      prev_fs = 1'b1; prev_sclk = 1'b1; prev_conv = 1'b0;
      if (!rst_n) cfg_word = '0;
    end else begin
      if (adc_rst_o) rst_cnt++;
      if (done_o) done_cnt++;
      if (prev_fs && !adc_fs_n_o) begin
        nfall = 0; flen = 0; in_sr = '0;
        if (frm_cnt < 4) begin
          busy_at_fs[frm_cnt] = busy_r;
          conv_at_fs[frm_cnt] = conv_cnt;
        end
        for (int k = 0; k < 3; k++) out_sr[k] = cfg_word[17] ? cfg_word : lane_d[k];
      end
      if (!adc_fs_n_o) flen++;
      if (!adc_fs_n_o && prev_sclk && !adc_sclk_o) begin
        in_sr = {in_sr[30:0], adc_sdi_o};
        nfall++;
      end
      if (!adc_fs_n_o && !prev_sclk && adc_sclk_o)
        for (int k = 0; k < 3; k++) out_sr[k] = {out_sr[k][30:0], 1'b0};
      if (!prev_fs && adc_fs_n_o) begin
        if (frm_cnt < 4) begin
          frm_word[frm_cnt] = in_sr; frm_bits[frm_cnt] = nfall; frm_len[frm_cnt] = flen;
        end
        if (frm_cnt == 0) cfg_word = in_sr;
        frm_cnt++;
      end
      if (adc_convst_o && !prev_conv) begin
        conv_cnt++;
        if (busy_mode != 0) bz_tmr = 1;
      end
      if (bz_tmr > 0) begin
        bz_tmr++;
        if (bz_tmr == 6) busy_r = 1'b1;
        if (busy_mode == 1 && bz_tmr == 46) begin busy_r = 1'b0; bz_tmr = 0; end
      end
      prev_fs = adc_fs_n_o; prev_sclk = adc_sclk_o; prev_conv = adc_convst_o;
    end
  end

  // ---------------- checking ----------------
  int n_chk = 0, n_fail = 0, cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      $display("FAIL R7 watchdog: cycles=%0d expected<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_chk + 1, n_fail + 1);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic begin_seq(input logic [31:0] w, input logic [31:0] l0, input logic [31:0] l1,
                           input logic [31:0] l2, input int mode);
    @(posedge clk); #1;
    lane_d[0] = l0; lane_d[1] = l1; lane_d[2] = l2;
    busy_mode = mode; ctrl_word_i = w; start_i = 1'b1; mdl_clr = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0; mdl_clr = 1'b0;
  endtask

  task automatic end_seq();
    for (int i = 0; i < 20000 && !(done_o || err_o); i++) begin
      @(posedge clk); #1;
    end
    repeat (20) @(posedge clk);
    #1;
  endtask

  initial begin
    lane_d[0] = '0; lane_d[1] = '0; lane_d[2] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R12: reset state
    chk("R12 fs_n idle",   {31'b0, adc_fs_n_o},   32'd1);
    chk("R12 sclk idle",   {31'b0, adc_sclk_o},   32'd1);
    chk("R12 rst/convst",  {30'b0, adc_rst_o, adc_convst_o}, 32'd0);
    chk("R12 done/err",    {30'b0, done_o, err_o}, 32'd0);
    chk("R12 res0",        res0_o | res1_o | res2_o, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // Table walk: main path
    for (int v = 0; v < 4; v++) begin
      logic [31:0] w, e0, e1, e2;
      w  = VEC[v][127:96];
      e0 = w[17] ? w : VEC[v][95:64];
      e1 = w[17] ? w : VEC[v][63:32];
      e2 = w[17] ? w : VEC[v][31:0];
      begin_seq(w, VEC[v][95:64], VEC[v][63:32], VEC[v][31:0], 1);
      end_seq();
      chk("R1 reset pulse cycles",  rst_cnt, RST_CYC);
      chk("R1 reset >= 50 ns",      {31'b0, (rst_cnt * 4 >= 50)}, 32'd1);
      chk("R2 cfg frame falls",     frm_bits[0], 32);
      chk("R2 cfg frame length",    frm_len[0], FRAME_CYC);
      chk("R2 read frame falls",    frm_bits[1], 32);
      chk("R3 cfg word sent",       frm_word[0], w);
      chk("R4 no convst before cfg", conv_at_fs[0], 0);
      chk("R4 one convst before rd", conv_at_fs[1], 1);
      chk("R5 busy low at read",    {31'b0, busy_at_fs[1]}, 32'd0);
      chk("R5 two frames",          frm_cnt, 2);
      chk("R6 word resent",         frm_word[1], w);
      chk("R6 lane0",               res0_o, e0);
      chk("R6 lane1",               res1_o, e1);
      chk("R6 lane2",               res2_o, e2);
      chk("R7 one done cycle",      done_cnt, 1);
      chk("R7 no error",            {31'b0, err_o}, 32'd0);
    end

    // R4: conversion-start width, measured directly
    begin
      int w_cnt;
      begin_seq(32'hE001_0000, 32'h1, 32'h2, 32'h3, 1);
      w_cnt = 0;
      for (int i = 0; i < 400 && !adc_convst_o; i++) begin @(posedge clk); #1; end
      for (int i = 0; i < 40 && adc_convst_o; i++) begin w_cnt++; @(posedge clk); #1; end
      chk("R4 convst width", w_cnt, CONV_CYC);
      end_seq();
      chk("R7 results hold", res2_o, 32'h3);
    end

    // R8: busy never rises
    begin_seq(32'hE001_0000, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 0);
    end_seq();
    chk("R8 err set",          {31'b0, err_o}, 32'd1);
    chk("R8 no read frame",    frm_cnt, 1);
    chk("R8 no done",          done_cnt, 0);
    chk("R8 results unchanged", res0_o, 32'h1);

    // R10: error clears after accepted start; R9: busy stuck high
    begin_seq(32'hE001_0000, 32'h4444_4444, 32'h5555_5555, 32'h6666_6666, 2);
    chk("R10 err cleared at start", {31'b0, err_o}, 32'd0);
    end_seq();
    chk("R9 err set",          {31'b0, err_o}, 32'd1);
    chk("R9 no read frame",    frm_cnt, 1);
    chk("R9 no done",          done_cnt, 0);
    chk("R9 results unchanged", res1_o, 32'h2);
    repeat (50) @(posedge clk);
    chk("R10 err held in idle", {31'b0, err_o}, 32'd1);

    // R11: second start during busy wait is ignored
    begin_seq(32'hE001_00AA, 32'h0BAD_F00D, 32'h600D_CAFE, 32'h1357_9BDF, 1);
    repeat (170) @(posedge clk);
    #1;
    ctrl_word_i = 32'hE003_FFFF; start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    end_seq();
    repeat (300) @(posedge clk);
    #1;
    chk("R11 only two frames",   frm_cnt, 2);
    chk("R11 cfg word kept",     frm_word[0], 32'hE001_00AA);
    chk("R11 read word kept",    frm_word[1], 32'hE001_00AA);
    chk("R11 result from first", res0_o, 32'h0BAD_F00D);
    chk("R10 err cleared by good run", {31'b0, err_o}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule